// File: doc/BRIEF.md
# Retrace Busy-Line History Monitor

This block measures how much of each vertical retrace interval a controlling processor spends busy. Utilization is counted in whole scan-line periods: every line period inside the retrace window during which the processor's busy flag was high at least once adds one unit. One line period is 800 pixel clocks in the target timing, and a retrace window holds 45 of them.

When the retrace window closes, the count for that window is written into a rolling history of the last 15 windows. The newest result replaces the oldest. A read index selects one history entry, with index 0 the most recent window, and the selected count appears one clock later. A sticky overflow flag records that the processor was still busy at the moment retrace ended. This means the window was fully consumed and work spilled into active video. Software clears the flag with a one-cycle write strobe.

Top module: `rtu_util_monitor`

## Requirements
- R1: After reset, all 15 history entries read as 0 and `overflow` is 0.
- R2: A line period inside retrace counts as one unit if `busy` is high in at least one clock of that line. A line starts at the clock where `hsync` is first sampled high. The committed value equals the number of such lines.
- R3: A line period in which `busy` stays low adds nothing. `busy` while `retrace_active` is low adds nothing to any count.
- R4: A window's count saturates at 45 and never exceeds it, however many busy lines occur.
- R5: The count is committed on the first clock at which `retrace_active` is sampled low after being high. Afterwards, `rd_idx` = 0 reads that window and `rd_idx` = k reads the window k commits earlier.
- R6: The history holds 15 windows. A 16th commit discards the oldest one. Any `rd_idx` of 15 or more reads 0.
- R7: `overflow` becomes 1 if `busy` is high on the first clock at which `retrace_active` is sampled low. It then stays 1 until cleared, and it is not set at any other time.
- R8: A high `ovf_clear` clears `overflow` on the next clock. If a set condition occurs in the same clock, the set wins.
- R9: `rd_count` is registered: it shows the entry selected by `rd_idx` at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Horizontal sync; rising level marks a new line |
| retrace_active | input | 1 | High during the vertical retrace window |
| busy | input | 1 | Processor busy flag |
| ovf_clear | input | 1 | Software strobe that clears the overflow flag |
| rd_idx | input | 4 | History index, 0 = newest |
| rd_count | output | 6 | Busy-line count of the selected entry (one-cycle latency) |
| overflow | output | 1 | Sticky flag: busy still high as retrace ended |

## Verification
A wrong line-busy or count register shows up as an off-by-one or missing unit in entry 0. This appears on the clock after retrace falls and is visible one read cycle later. A faulty write pointer or index map puts a correct value under the wrong index, or destroys an older entry. This shows within one commit when entries are read back newest-first. The overflow flag is observed directly on the clock after its set or clear condition, so errors in stickiness or set/clear priority appear within one cycle.

// File: rtl/rtu_pkg.sv
package rtu_pkg;
   // How rd_idx selects a history slot
   typedef enum logic {
      IDX_NEWEST_FIRST = 1'b0,
      IDX_PHYSICAL     = 1'b1
   } rtu_idx_mode_e;
endpackage

// File: rtl/rtu_line_counter.sv
module rtu_line_counter #(
   parameter int MAX_LINES      = 45,
   parameter int CNT_W          = 6,
   parameter bit HS_ACTIVE_HIGH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsync,
   input  logic             retrace,
   input  logic             busy,
   output logic             commit,
   output logic [CNT_W-1:0] commit_count
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_LINES);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic             hs_lvl;
   logic             hs_q;
   logic             rt_q;
   logic             line_busy;
   logic [CNT_W-1:0] lines_used;
   logic             line_start;
   logic [CNT_W-1:0] lines_inc;

   generate
      if (HS_ACTIVE_HIGH) begin : g_hs_pos
         assign hs_lvl = hsync;
      end else begin : g_hs_neg
         assign hs_lvl = ~hsync;
      end
   endgenerate

   assign line_start = hs_lvl & ~hs_q;
   assign commit     = rt_q & ~retrace;
   // saturating increment of the per-window count
   assign lines_inc  = (lines_used == CNT_MAX) ? lines_used : lines_used + CNT_ONE;
   // the line still open at window close is included in the result
   assign commit_count = line_busy ? lines_inc : lines_used;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_q       <= 1'b0;
         rt_q       <= 1'b0;
         line_busy  <= 1'b0;
         lines_used <= '0;
      end else begin
         hs_q <= hs_lvl;
         rt_q <= retrace;
         if (commit) begin
            line_busy  <= 1'b0;
            lines_used <= '0;
         end else if (retrace) begin
            if (line_start) begin
               if (line_busy) lines_used <= lines_inc;
               line_busy <= busy;
            end else begin
               line_busy <= line_busy | busy;
            end
         end
      end
   end
endmodule

// File: rtl/rtu_index_map.sv
module rtu_index_map #(
   parameter int DEPTH = 15,
   parameter int IDX_W = 4,
   parameter rtu_pkg::rtu_idx_mode_e IDX_MODE = rtu_pkg::IDX_NEWEST_FIRST
) (
   input  logic [IDX_W-1:0] wr_ptr,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [IDX_W-1:0] slot,
   output logic             in_range
);
   localparam logic [IDX_W:0] DEPTH_X   = (IDX_W+1)'(DEPTH);
   localparam logic [IDX_W:0] DEPTH_M1X = (IDX_W+1)'(DEPTH - 1);

   assign in_range = ({1'b0, rd_idx} < DEPTH_X);

   generate
      if (IDX_MODE == rtu_pkg::IDX_NEWEST_FIRST) begin : g_newest
         logic [IDX_W:0] raw;
         logic [IDX_W:0] wrapped;
         // newest entry sits just below the write pointer
         assign raw     = {1'b0, wr_ptr} + DEPTH_M1X - {1'b0, rd_idx};
         assign wrapped = (raw >= DEPTH_X) ? raw - DEPTH_X : raw;
         assign slot    = wrapped[IDX_W-1:0];
      end else begin : g_physical
         assign slot = rd_idx;
      end
   endgenerate
endmodule

// File: rtl/rtu_history_store.sv
module rtu_history_store #(
   parameter int DEPTH = 15,
   parameter int CNT_W = 6,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [IDX_W-1:0] wr_ptr,
   input  logic [IDX_W-1:0] rd_slot,
   input  logic             rd_ok,
   output logic [CNT_W-1:0] rd_data
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
   localparam logic [IDX_W-1:0] ONE  = IDX_W'(1);

   logic [CNT_W-1:0] slots [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
      end else if (wr_en) begin
         wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + ONE;
      end
   end

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               slots[i] <= '0;
            end else if (wr_en && (wr_ptr == IDX_W'(i))) begin
               slots[i] <= wr_data;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else begin
         rd_data <= rd_ok ? slots[rd_slot] : '0;
      end
   end
endmodule

// File: rtl/rtu_ovf_flag.sv
module rtu_ovf_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic window_end,
   input  logic busy,
   input  logic clear,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (window_end && busy) begin
         flag <= 1'b1;
      end else if (clear) begin
         flag <= 1'b0;
      end
   end
endmodule

// File: rtl/rtu_util_monitor.sv
module rtu_util_monitor #(
   parameter int MAX_LINES      = 45,
   parameter int DEPTH          = 15,
   parameter bit HS_ACTIVE_HIGH = 1'b1,
   parameter rtu_pkg::rtu_idx_mode_e IDX_MODE = rtu_pkg::IDX_NEWEST_FIRST,
   localparam int CNT_W = $clog2(MAX_LINES + 1),
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsync,
   input  logic             retrace_active,
   input  logic             busy,
   input  logic             ovf_clear,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CNT_W-1:0] rd_count,
   output logic             overflow
);
   generate
      if (MAX_LINES < 1) begin : g_bad_lines
         $error("MAX_LINES must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
   endgenerate

   logic             commit;
   logic [CNT_W-1:0] commit_count;
   logic [IDX_W-1:0] wr_ptr;
   logic [IDX_W-1:0] rd_slot;
   logic             rd_ok;

   rtu_line_counter #(
      .MAX_LINES(MAX_LINES), .CNT_W(CNT_W), .HS_ACTIVE_HIGH(HS_ACTIVE_HIGH)
   ) u_count (
      .clk(clk), .rst_n(rst_n), .hsync(hsync), .retrace(retrace_active),
      .busy(busy), .commit(commit), .commit_count(commit_count)
   );

   rtu_index_map #(
      .DEPTH(DEPTH), .IDX_W(IDX_W), .IDX_MODE(IDX_MODE)
   ) u_map (
      .wr_ptr(wr_ptr), .rd_idx(rd_idx), .slot(rd_slot), .in_range(rd_ok)
   );

   rtu_history_store #(
      .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)
   ) u_hist (
      .clk(clk), .rst_n(rst_n), .wr_en(commit), .wr_data(commit_count),
      .wr_ptr(wr_ptr), .rd_slot(rd_slot), .rd_ok(rd_ok), .rd_data(rd_count)
   );

   rtu_ovf_flag u_ovf (
      .clk(clk), .rst_n(rst_n), .window_end(commit), .busy(busy),
      .clear(ovf_clear), .flag(overflow)
   );
endmodule

// File: rtl/rtu_util_monitor_chk.sv
module rtu_util_monitor_chk #(
   parameter int MAX_LINES = 45,
   parameter int DEPTH     = 15,
   parameter int CNT_W     = 6,
   parameter int IDX_W     = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             retrace_active,
   input logic             busy,
   input logic             ovf_clear,
   input logic [IDX_W-1:0] rd_idx,
   input logic [CNT_W-1:0] rd_count,
   input logic             overflow,
   input logic [IDX_W-1:0] wr_ptr
);
   assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(rd_count) <= MAX_LINES);

   assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(wr_ptr) < DEPTH);

   assert_oob_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_idx) >= DEPTH) |=> (rd_count == '0));

   assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(retrace_active) && busy) |=> overflow);

   assert_ovf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !ovf_clear) |=> overflow);

   assert_no_spurious_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!overflow && !($fell(retrace_active) && busy)) |=> !overflow);

   assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_clear && !($fell(retrace_active) && busy)) |=> !overflow);
endmodule

bind rtu_util_monitor rtu_util_monitor_chk #(
   .MAX_LINES(MAX_LINES), .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .retrace_active(retrace_active), .busy(busy),
   .ovf_clear(ovf_clear), .rd_idx(rd_idx), .rd_count(rd_count),
   .overflow(overflow), .wr_ptr(wr_ptr)
);

// File: tb/tb_rtu_util_monitor.sv
module tb_rtu_util_monitor;
   localparam int LINE_CLKS = 8;
   localparam int NLIM      = 45;
   localparam int NHIST     = 15;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hsync = 1'b0;
   logic       retrace_active = 1'b0;
   logic       busy = 1'b0;
   logic       ovf_clear = 1'b0;
   logic [3:0] rd_idx = '0;
   logic [5:0] rd_count;
   logic       overflow;

   int checks = 0;
   int errors = 0;
   int exp_hist [NHIST];
   bit done = 1'b0;

   always #5 clk = ~clk;

   rtu_util_monitor dut (
      .clk(clk), .rst_n(rst_n), .hsync(hsync), .retrace_active(retrace_active),
      .busy(busy), .ovf_clear(ovf_clear), .rd_idx(rd_idx),
      .rd_count(rd_count), .overflow(overflow)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int ones(input logic [63:0] m, input int n);
      int c = 0;
      for (int i = 0; i < n; i++) c += int'(m[i]);
      return c;
   endfunction

   function automatic void push_exp(input int v);
      for (int i = NHIST - 1; i > 0; i--) exp_hist[i] = exp_hist[i-1];
      exp_hist[0] = v;
   endfunction

   task automatic read_entry(input int idx, output int v);
      @(negedge clk);
      rd_idx = 4'(idx);
      @(negedge clk);
      v = int'(rd_count);
   endtask

   // one retrace window: 'lines' lines, busy for one clock in lines flagged by mask
   task automatic run_retrace(input int lines, input logic [63:0] mask,
                              input bit end_busy, input bit end_clear);
      int exp_v;
      @(negedge clk);
      retrace_active = 1'b1;
      for (int l = 0; l < lines; l++) begin
         for (int c = 0; c < LINE_CLKS; c++) begin
            hsync = (c == 0);
            busy  = (l < 64) ? (mask[l] && c == 3) : 1'b1;
            if (c != 3 && l >= 64) busy = 1'b0;
            @(negedge clk);
         end
      end
      hsync = 1'b0;
      retrace_active = 1'b0;
      busy = end_busy;
      ovf_clear = end_clear;
      @(negedge clk);
      busy = 1'b0;
      ovf_clear = 1'b0;
      exp_v = (lines > 64) ? lines : ones(mask, lines);
      if (exp_v > NLIM) exp_v = NLIM;
      push_exp(exp_v);
   endtask

   task automatic t_reset();
      int v;
      check("R1 overflow after reset", int'(overflow), 0);
      for (int i = 0; i < NHIST; i++) begin
         read_entry(i, v);
         check("R1 entry zero after reset", v, 0);
      end
   endtask

   task automatic t_basic_count();
      int v;
      run_retrace(45, 64'h0000_0000_0000_00A5, 1'b0, 1'b0);
      read_entry(0, v);
      check("R2 sparse busy lines", v, exp_hist[0]);
      run_retrace(10, 64'h0000_0000_0000_03FF, 1'b0, 1'b0);
      read_entry(0, v);
      check("R2 all ten lines busy", v, 10);
      read_entry(1, v);
      check("R5 previous window at index 1", v, 4);
      check("R3 no overflow without busy at end", int'(overflow), 0);
   endtask

   task automatic t_outside_busy();
      int v;
      // busy with no retrace, including hsync pulses
      @(negedge clk);
      busy = 1'b1;
      for (int c = 0; c < 3 * LINE_CLKS; c++) begin
         hsync = (c % LINE_CLKS == 0);
         @(negedge clk);
      end
      busy = 1'b0;
      hsync = 1'b0;
      read_entry(0, v);
      check("R3 busy outside retrace does not commit", v, 10);
      check("R3 busy outside retrace leaves overflow", int'(overflow), 0);
      run_retrace(45, 64'h0, 1'b0, 1'b0);
      read_entry(0, v);
      check("R3 idle window counts zero", v, 0);
   endtask

   task automatic t_saturate();
      int v;
      run_retrace(50, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
      read_entry(0, v);
      check("R4 saturates at 45", v, NLIM);
      run_retrace(45, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
      read_entry(0, v);
      check("R4 exactly 45 lines", v, NLIM);
   endtask

   task automatic t_rolling();
      int v;
      for (int k = 1; k <= 16; k++) run_retrace(20, (64'd1 << k) - 64'd1, 1'b0, 1'b0);
      for (int i = 0; i < NHIST; i++) begin
         read_entry(i, v);
         check("R6 rolling history order", v, exp_hist[i]);
      end
      check("R6 oldest dropped, index 14", exp_hist[14], 2);
      read_entry(15, v);
      check("R6 out of range index", v, 0);
   endtask

   task automatic t_read_latency();
      int v;
      read_entry(0, v);
      @(negedge clk);
      rd_idx = 4'd5;
      #1;
      check("R9 output holds before edge", int'(rd_count), exp_hist[0]);
      @(negedge clk);
      check("R9 output updates after one edge", int'(rd_count), exp_hist[5]);
   endtask

   task automatic t_overflow();
      int v;
      run_retrace(12, 64'h3, 1'b1, 1'b0);
      check("R7 overflow set by busy at window end", int'(overflow), 1);
      read_entry(0, v);
      check("R2 end-cycle busy not counted", v, 2);
      repeat (5) @(negedge clk);
      check("R7 overflow sticky", int'(overflow), 1);
      run_retrace(5, 64'h0, 1'b0, 1'b0);
      check("R7 overflow stays through next window", int'(overflow), 1);
      @(negedge clk);
      ovf_clear = 1'b1;
      @(negedge clk);
      ovf_clear = 1'b0;
      check("R8 clear strobe clears overflow", int'(overflow), 0);
      run_retrace(5, 64'h1, 1'b1, 1'b1);
      check("R8 set wins over clear", int'(overflow), 1);
      @(negedge clk);
      ovf_clear = 1'b1;
      @(negedge clk);
      ovf_clear = 1'b0;
      check("R8 second clear", int'(overflow), 0);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NHIST; i++) exp_hist[i] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic_count();
      t_outside_busy();
      t_saturate();
      t_rolling();
      t_read_latency();
      t_overflow();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule